// File: doc/BRIEF.md
# Cache Fill Qualifier

This block sits between the external bus cycle tracker of a processor and its on-chip cache. At the start of each bus cycle it records the cycle's attributes: memory or I/O space, read or write, locked or not, the word address and the byte enables. At that same start edge it checks the address against four programmable non-cacheable regions. When the cycle ends with ready sampled active, it decides whether the returned word may be written into the cache. If so, it emits a one-clock fill strobe together with the word address, the word index within a 16-byte line, the data and the byte mask to write.

A per-cycle external cache-enable input can veto caching, but only while a configuration bit is set. The block samples that input on the clock edge just before the ready edge, and only that sample counts. When the enable is honoured and asserted, the whole bus word is written whatever the byte enables say. Changes to the region and configuration registers take effect only from the next bus cycle that starts after the write.

Top module: `cache_fill_qualifier`

## Requirements
- R1: A write cycle, an I/O cycle (busMem low) or a locked cycle never produces a fill strobe.
- R2: With configuration bit 0 clear, an unlocked memory read outside every active region produces a fill when ready is sampled. Its fillByteEn equals the active-high byte enables captured at cycle start.
- R3: A read whose address is inside any active region never produces a fill, whatever the level of cacheEnIn.
- R4: Region register i (cfgWrSel = i, 0..3) takes its base from cfgWrData[31:12] and its size code from cfgWrData[3:0]. Code 0 disables the region. Code k covers 4 KiB << (k-1) bytes. An address matches when its bits above the region size equal the base's bits.
- R5: With configuration bit 0 set (cfgWrSel = 4, cfgWrData[0]), a fill happens only if cacheEnIn was high at the clock edge immediately before the ready edge. Its level at the ready edge and at earlier edges has no effect.
- R6: With configuration bit 0 clear, cacheEnIn has no effect: a qualifying read fills even with cacheEnIn low.
- R7: When cacheEnIn is honoured and asserted, fillByteEn is all ones whatever busBe is.
- R8: fillValid is high for exactly one clock, in the clock after the ready edge. In that clock fillAddr is the cycle's word address, fillWord is address bits [3:2], and fillData is busData as sampled at the ready edge.
- R9: A cycle cut short by reset produces no fill. Ready while no cycle is in progress produces no fill.
- R10: A register write made in the same clock as cycStart, or during a cycle, does not affect that cycle. It applies from the next cycle started after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgWrSel | input | 3 | Register select: 0..3 regions, 4 configuration |
| cfgWrData | input | 32 | Register write data |
| cycStart | input | 1 | First clock of a bus cycle; attributes valid |
| busAddr | input | 30 | Word address bits [31:2] |
| busMem | input | 1 | 1 = memory space, 0 = I/O |
| busWrite | input | 1 | 1 = write cycle |
| busLock | input | 1 | 1 = locked cycle |
| busBe | input | 4 | Active-high byte enables |
| cacheEnIn | input | 1 | Per-cycle external cache enable |
| busReady | input | 1 | Ready strobe ending the cycle |
| busData | input | 32 | Read data bus |
| fillValid | output | 1 | One-clock fill strobe |
| fillAddr | output | 30 | Word address of the fill |
| fillWord | output | 2 | Word index within the 16-byte line |
| fillByteEn | output | 4 | Byte lanes to write |
| fillData | output | 32 | Data word to write |

## Verification
The hardest case to reach is the one where cacheEnIn is sampled on exactly one edge. The bench drives it high only on the edge just before ready and low on all others. It also runs the mirror pattern, low before ready and high at the ready edge, so a design that samples one clock off fails one of the two. Register writes are also driven in the very clock a cycle starts and in the middle of a cycle. After each, the same address is run again in the following cycle, which shows that the change reaches the next cycle and not the one already in progress.

// File: rtl/cfq_pkg.sv
`timescale 1ns/1ps
package cfq_pkg;

  // Strobes sent from the control to the datapath.
  typedef struct packed {
    logic capture;   // latch cycle attributes and region verdict
    logic fillLoad;  // register a fill toward the cache
  } cfqStrobe_t;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACTIVE = 1'b1
  } cfqState_t;

endpackage

// File: rtl/cfq_ctrl.sv
`timescale 1ns/1ps
module cfq_ctrl
  import cfq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycStart,
  input  logic       busReady,
  input  logic       candQ,
  input  logic       honorQ,
  input  logic       kenQ,
  output cfqStrobe_t strb
);

  cfqState_t state;
  cfqState_t stateNext;
  logic      readyInCycle;
  logic      kenAllows;

  // Ready counts only for a cycle already started on an earlier edge.
  assign readyInCycle = (state == ST_ACTIVE) && busReady && !cycStart;
  assign kenAllows    = !honorQ || kenQ;

  always_comb begin
    strb          = '0;
    strb.capture  = cycStart;
    strb.fillLoad = readyInCycle && candQ && kenAllows;
  end

  always_comb begin
    stateNext = state;
    if (cycStart) begin
      stateNext = ST_ACTIVE;
    end else if (readyInCycle) begin
      stateNext = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  AST_START_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    cycStart |=> (state == ST_ACTIVE)) else $error("start did not open cycle"); // R8
  AST_FILL_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillLoad |=> (state == ST_IDLE)) else $error("cycle still open after fill"); // R9

endmodule

// File: rtl/cfq_dpath.sv
`timescale 1ns/1ps
module cfq_dpath
  import cfq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int NUM_REGIONS = 4,
  parameter int MIN_LG      = 12,
  parameter int LINE_BYTES  = 16,
  parameter int CODE_W      = 4,
  localparam int WORD_BYTES = DATA_W / 8,
  localparam int WORD_LSB   = $clog2(WORD_BYTES),
  localparam int IDX_W      = $clog2(LINE_BYTES / WORD_BYTES),
  localparam int TAG_W      = ADDR_W - MIN_LG,
  localparam int SEL_W      = $clog2(NUM_REGIONS + 1)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgWrEn,
  input  logic [SEL_W-1:0]           cfgWrSel,
  input  logic [DATA_W-1:0]          cfgWrData,
  input  logic [ADDR_W-1:WORD_LSB]   busAddr,
  input  logic                       busMem,
  input  logic                       busWrite,
  input  logic                       busLock,
  input  logic [WORD_BYTES-1:0]      busBe,
  input  logic                       cacheEnIn,
  input  logic [DATA_W-1:0]          busData,
  input  cfqStrobe_t                 strb,
  output logic                       candQ,
  output logic                       honorQ,
  output logic                       kenQ,
  output logic                       fillValid,
  output logic [ADDR_W-1:WORD_LSB]   fillAddr,
  output logic [IDX_W-1:0]           fillWord,
  output logic [WORD_BYTES-1:0]      fillByteEn,
  output logic [DATA_W-1:0]          fillData
);

  // Programmable state
  logic [TAG_W-1:0]  regBase [NUM_REGIONS];
  logic [CODE_W-1:0] regCode [NUM_REGIONS];
  logic              honorCfg;
  logic              unusedCfgBits;

  assign unusedCfgBits = ^cfgWrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      honorCfg <= 1'b0;
    end else if (cfgWrEn && (cfgWrSel == SEL_W'(NUM_REGIONS))) begin
      honorCfg <= cfgWrData[0];
    end
  end

  // Region registers and address comparators
  logic [NUM_REGIONS-1:0] hitVec;
  logic [TAG_W-1:0]       addrTag;

  assign addrTag = busAddr[ADDR_W-1:MIN_LG];

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    logic [TAG_W-1:0] sizeMask;
    logic             enabled;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regBase[g] <= '0;
        regCode[g] <= '0;
      end else if (cfgWrEn && (cfgWrSel == SEL_W'(g))) begin
        regBase[g] <= cfgWrData[ADDR_W-1:MIN_LG];
        regCode[g] <= cfgWrData[CODE_W-1:0];
      end
    end

    assign enabled = (regCode[g] != '0);

    always_comb begin
      if (enabled) begin
        sizeMask = {TAG_W{1'b1}} << (regCode[g] - CODE_W'(1));
      end else begin
        sizeMask = '0;
      end
    end

    assign hitVec[g] = enabled && (((addrTag ^ regBase[g]) & sizeMask) == '0);
  end

  logic regionHit;
  logic candNow;

  assign regionHit = |hitVec;
  assign candNow   = busMem && !busWrite && !busLock && !regionHit;

  // Per-cycle capture
  logic [ADDR_W-1:WORD_LSB] addrQ;
  logic [WORD_BYTES-1:0]    beQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      candQ  <= 1'b0;
      honorQ <= 1'b0;
      addrQ  <= '0;
      beQ    <= '0;
    end else if (strb.capture) begin
      candQ  <= candNow;
      honorQ <= honorCfg;
      addrQ  <= busAddr;
      beQ    <= busBe;
    end
  end

  // External enable sampled every edge; at the ready edge this holds
  // the level seen one clock earlier.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kenQ <= 1'b0;
    end else begin
      kenQ <= cacheEnIn;
    end
  end

  // Fill output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillValid  <= 1'b0;
      fillAddr   <= '0;
      fillWord   <= '0;
      fillByteEn <= '0;
      fillData   <= '0;
    end else begin
      fillValid <= strb.fillLoad;
      if (strb.fillLoad) begin
        fillAddr   <= addrQ;
        fillWord   <= addrQ[WORD_LSB+IDX_W-1:WORD_LSB];
        fillData   <= busData;
        fillByteEn <= honorQ ? {WORD_BYTES{1'b1}} : beQ;
      end
    end
  end

  AST_FILL_NEEDS_CAND: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillLoad |-> candQ) else $error("fill on non-candidate cycle"); // R1
  AST_KEN_GATES_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fillLoad && honorQ) |-> kenQ) else $error("fill without enable"); // R5
  AST_FULL_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.fillLoad && honorQ) |=> (fillByteEn == {WORD_BYTES{1'b1}})) else $error("partial mask"); // R7
  AST_FILL_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |=> !fillValid) else $error("fill strobe longer than a clock"); // R8

endmodule

// File: rtl/cache_fill_qualifier.sv
`timescale 1ns/1ps
module cache_fill_qualifier
  import cfq_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int NUM_REGIONS = 4,
  parameter int MIN_LG      = 12,
  parameter int LINE_BYTES  = 16,
  parameter int CODE_W      = 4,
  localparam int WORD_BYTES = DATA_W / 8,
  localparam int WORD_LSB   = $clog2(WORD_BYTES),
  localparam int IDX_W      = $clog2(LINE_BYTES / WORD_BYTES),
  localparam int SEL_W      = $clog2(NUM_REGIONS + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWrEn,
  input  logic [SEL_W-1:0]         cfgWrSel,
  input  logic [DATA_W-1:0]        cfgWrData,
  input  logic                     cycStart,
  input  logic [ADDR_W-1:WORD_LSB] busAddr,
  input  logic                     busMem,
  input  logic                     busWrite,
  input  logic                     busLock,
  input  logic [WORD_BYTES-1:0]    busBe,
  input  logic                     cacheEnIn,
  input  logic                     busReady,
  input  logic [DATA_W-1:0]        busData,
  output logic                     fillValid,
  output logic [ADDR_W-1:WORD_LSB] fillAddr,
  output logic [IDX_W-1:0]         fillWord,
  output logic [WORD_BYTES-1:0]    fillByteEn,
  output logic [DATA_W-1:0]        fillData
);

  cfqStrobe_t strb;
  logic       candQ;
  logic       honorQ;
  logic       kenQ;

  cfq_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cycStart (cycStart),
    .busReady (busReady),
    .candQ    (candQ),
    .honorQ   (honorQ),
    .kenQ     (kenQ),
    .strb     (strb)
  );

  cfq_dpath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .NUM_REGIONS (NUM_REGIONS),
    .MIN_LG      (MIN_LG),
    .LINE_BYTES  (LINE_BYTES),
    .CODE_W      (CODE_W)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgWrSel   (cfgWrSel),
    .cfgWrData  (cfgWrData),
    .busAddr    (busAddr),
    .busMem     (busMem),
    .busWrite   (busWrite),
    .busLock    (busLock),
    .busBe      (busBe),
    .cacheEnIn  (cacheEnIn),
    .busData    (busData),
    .strb       (strb),
    .candQ      (candQ),
    .honorQ     (honorQ),
    .kenQ       (kenQ),
    .fillValid  (fillValid),
    .fillAddr   (fillAddr),
    .fillWord   (fillWord),
    .fillByteEn (fillByteEn),
    .fillData   (fillData)
  );

  AST_FILL_AFTER_READY: assert property (@(posedge clk) disable iff (!rstN)
    fillValid |-> $past(busReady)) else $error("fill without ready"); // R8

endmodule

// File: tb/cache_fill_qualifier_bench.sv
`timescale 1ns/1ps
module cache_fill_qualifier_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgWrSel = '0;
  logic [31:0] cfgWrData = '0;
  logic        cycStart = 1'b0;
  logic [31:2] busAddr = '0;
  logic        busMem = 1'b0;
  logic        busWrite = 1'b0;
  logic        busLock = 1'b0;
  logic [3:0]  busBe = '0;
  logic        cacheEnIn = 1'b0;
  logic        busReady = 1'b0;
  logic [31:0] busData = '0;
  logic        fillValid;
  logic [31:2] fillAddr;
  logic [1:0]  fillWord;
  logic [3:0]  fillByteEn;
  logic [31:0] fillData;

  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  cache_fill_qualifier u_cache_fill_qualifier (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .cfgWrData(cfgWrData), .cycStart(cycStart), .busAddr(busAddr),
    .busMem(busMem), .busWrite(busWrite), .busLock(busLock), .busBe(busBe),
    .cacheEnIn(cacheEnIn), .busReady(busReady), .busData(busData),
    .fillValid(fillValid), .fillAddr(fillAddr), .fillWord(fillWord),
    .fillByteEn(fillByteEn), .fillData(fillData)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // Drive the start clock; one rising edge passes.
  task automatic startCycle(input logic [31:0] addr, input bit mem, input bit wr,
                            input bit lock, input logic [3:0] be);
    cycStart = 1'b1; busAddr = addr[31:2]; busMem = mem;
    busWrite = wr; busLock = lock; busBe = be;
    @(negedge clk);
    cycStart = 1'b0; cfgWrEn = 1'b0;
  endtask

  // One wait clock whose edge samples ken.
  task automatic waitClk(input bit ken);
    cacheEnIn = ken;
    @(negedge clk);
  endtask

  // Ready clock; after it the registered fill is visible.
  task automatic readyClk(input bit ken, input logic [31:0] data);
    cacheEnIn = ken; busReady = 1'b1; busData = data;
    @(negedge clk);
    busReady = 1'b0; cacheEnIn = 1'b0;
  endtask

  task automatic expectFill(input string req, input bit expV,
                            input logic [31:0] addr, input logic [3:0] be,
                            input logic [31:0] data);
    check(fillValid == expV, req, 64'(fillValid), 64'(expV));
    if (expV) begin
      check(fillAddr == addr[31:2], {req, " addr"}, 64'(fillAddr), 64'(addr[31:2]));
      check(fillWord == addr[3:2], {req, " word"}, 64'(fillWord), 64'(addr[3:2]));
      check(fillByteEn == be, {req, " bytes"}, 64'(fillByteEn), 64'(be));
      check(fillData == data, {req, " data"}, 64'(fillData), 64'(data));
    end
    @(negedge clk);
    check(fillValid == 1'b0, {req, " pulse"}, 64'(fillValid), 64'h0);
  endtask

  // Full cycle: start, early wait with kenEarly, pre-ready edge with kenPre,
  // ready edge with kenAt.
  task automatic runRead(input string req, input logic [31:0] addr, input bit mem,
                         input bit wr, input bit lock, input logic [3:0] be,
                         input bit kenEarly, input bit kenPre, input bit kenAt,
                         input logic [31:0] data, input bit expV,
                         input logic [3:0] expBe);
    startCycle(addr, mem, wr, lock, be);
    waitClk(kenEarly);
    waitClk(kenPre);
    readyClk(kenAt, data);
    expectFill(req, expV, addr, expBe, data);
  endtask

  task automatic testReset;
    check(fillValid == 1'b0, "R9 reset", 64'(fillValid), 64'h0);
  endtask

  task automatic testBasic; // R2 R6 R8
    runRead("R2", 32'h0000_1234, 1, 0, 0, 4'b0011, 0, 0, 0, 32'hA5A5_0001, 1, 4'b0011);
    runRead("R6", 32'h0000_2008, 1, 0, 0, 4'b1100, 1, 0, 0, 32'h1234_5678, 1, 4'b1100);
    runRead("R8", 32'h0000_300C, 1, 0, 0, 4'b1111, 0, 0, 0, 32'hDEAD_BEEF, 1, 4'b1111);
  endtask

  task automatic testReject; // R1
    runRead("R1 write", 32'h0000_4000, 1, 1, 0, 4'hF, 0, 0, 0, 32'h1, 0, 4'h0);
    runRead("R1 io",    32'h0000_4004, 0, 0, 0, 4'hF, 0, 0, 0, 32'h2, 0, 4'h0);
    runRead("R1 lock",  32'h0000_4008, 1, 0, 1, 4'hF, 0, 0, 0, 32'h3, 0, 4'h0);
  endtask

  task automatic testRegions; // R3 R4
    wrReg(3'd0, 32'h0010_0001);  // 4 KiB at 0x00100000
    wrReg(3'd1, 32'h0020_0003);  // 16 KiB at 0x00200000
    wrReg(3'd2, 32'h0030_0000);  // disabled
    runRead("R3 r0 hit",   32'h0010_0ABC, 1, 0, 0, 4'hF, 1, 1, 1, 32'h11, 0, 4'h0);
    runRead("R4 r0 edge",  32'h0010_1000, 1, 0, 0, 4'hF, 0, 0, 0, 32'h12, 1, 4'hF);
    runRead("R4 r1 top",   32'h0020_3FFC, 1, 0, 0, 4'hF, 0, 0, 0, 32'h13, 0, 4'h0);
    runRead("R4 r1 past",  32'h0020_4000, 1, 0, 0, 4'hF, 0, 0, 0, 32'h14, 1, 4'hF);
    runRead("R4 code0",    32'h0030_0010, 1, 0, 0, 4'hF, 0, 0, 0, 32'h15, 1, 4'hF);
  endtask

  task automatic testKen; // R5 R7 R3
    wrReg(3'd4, 32'h0000_0001);
    runRead("R7 full",    32'h0040_0004, 1, 0, 0, 4'b0001, 0, 1, 0, 32'h21, 1, 4'hF);
    runRead("R5 late",    32'h0040_0008, 1, 0, 0, 4'hF, 1, 0, 1, 32'h22, 0, 4'h0);
    runRead("R3 ken hit", 32'h0010_0040, 1, 0, 0, 4'hF, 1, 1, 1, 32'h23, 0, 4'h0);
    wrReg(3'd4, 32'h0000_0000);
  endtask

  task automatic testTiming; // R10
    // Write in the start clock: does not apply to this cycle.
    cfgWrEn = 1'b1; cfgWrSel = 3'd4; cfgWrData = 32'h1;
    startCycle(32'h0050_0000, 1, 0, 0, 4'b0101);
    waitClk(0);
    readyClk(0, 32'h31);
    expectFill("R10 same clk", 1, 32'h0050_0000, 4'b0101, 32'h31);
    runRead("R10 next", 32'h0050_0000, 1, 0, 0, 4'hF, 0, 0, 0, 32'h32, 0, 4'h0);
    wrReg(3'd4, 32'h0);
    // Region written mid-cycle: current cycle still fills, next does not.
    startCycle(32'h0060_0008, 1, 0, 0, 4'hF);
    cfgWrEn = 1'b1; cfgWrSel = 3'd3; cfgWrData = 32'h0060_0001;
    waitClk(0);
    cfgWrEn = 1'b0;
    readyClk(0, 32'h33);
    expectFill("R10 mid", 1, 32'h0060_0008, 4'hF, 32'h33);
    runRead("R10 after", 32'h0060_0008, 1, 0, 0, 4'hF, 0, 0, 0, 32'h34, 0, 4'h0);
  endtask

  task automatic testAbort; // R9
    readyClk(0, 32'h41);
    expectFill("R9 idle ready", 0, 32'h0, 4'h0, 32'h0);
    startCycle(32'h0070_0000, 1, 0, 0, 4'hF);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    waitClk(0);
    readyClk(0, 32'h42);
    expectFill("R9 reset abort", 0, 32'h0, 4'h0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testReject();
    testRegions();
    testKen();
    testTiming();
    testAbort();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    #1000000;
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule